// File: doc/BRIEF.md
# System Call Trap Entry Unit

This unit sits beside the execute stage of a simple in-order core that has no hypervisor. When decode hands it a system-call request, it looks at the request's 7-bit level field. It then either takes the system-call interrupt or turns the request into an illegal-instruction exception. A taken trap does four things in one clock. It records the address of the following instruction. It records the machine state that was in force. It writes a new machine state, changed field by field. It steers fetch to the system-call vector.

Any level above 1 is a reserved encoding and always faults. Level 1 asks for hypervisor entry. The build-time parameter `HV_ACCEPT` decides what happens to it. With `HV_ACCEPT=1` it traps to the same vector and marks the hypervisor-state bit. With `HV_ACCEPT=0` it faults. On a fault the unit reports a cause code and the faulting PC, and it leaves every piece of saved and machine state as it was.

Results are registered. A request sampled on one rising edge yields a one-cycle pulse on `trap_valid` or on `excp_valid` during the following cycle. The saved and new state stay on their outputs until the next accepted trap.

Top module: `sctrap_unit`

## Requirements
- R1: After reset, `trap_valid` and `excp_valid` are 0, and `srr0`, `srr1`, `new_msr`, `excp_pc` and `excp_cause` are all zero.
- R2: A request with level 0 gives `trap_valid`=1 in the cycle after it is sampled, with `redirect_pc` = `VEC_BASE` + 0xC00 (0xC00 by default).
- R3: A request with a level of 2 or more gives `excp_valid`=1 in the next cycle, with `excp_cause`=1 (reserved level) and `excp_pc` equal to the request PC. No trap is taken.
- R4: Level 1 with `HV_ACCEPT`=1 traps like R2 and sets `new_msr` bit 60 (hypervisor state) to 1. Level 1 with `HV_ACCEPT`=0 raises `excp_valid` with `excp_cause`=2 (hypervisor call rejected).
- R5: On a taken trap, `srr0` = request PC + 4 and `srr1` = the `cur_msr` value sampled with the request.
- R6: On a taken trap, `new_msr` bit 63 (64-bit mode) and bit 0 (little-endian) are 1.
- R7: On a taken trap, `new_msr` has 0 in each of these bits: 15 (external-interrupt enable), 14 (problem state), 5 (instruction relocate), 4 (data relocate), 1 (recoverable interrupt), 32 (transactional), 25 (vector), 23 (vector-scalar), 13 (floating point), 2 (performance-monitor mark), 58 (reserved), and 10:9 (trace enable).
- R8: On a trap that is not an accepted hypervisor call, `new_msr` bit 60 equals bit 60 of the sampled `cur_msr`. Every bit that R6 and R7 do not name is copied from `cur_msr`.
- R9: An illegal-instruction outcome leaves `srr0`, `srr1` and `new_msr` at their previous values, and `trap_valid` stays 0.
- R10: `fetch_pc` equals `redirect_pc` while `trap_valid` is 1, and equals `seq_pc` otherwise.
- R11: `trap_valid` and `excp_valid` are never 1 together. Each is a single-cycle pulse: with no request sampled, both are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sc_valid | input | 1 | Decoded system-call request present |
| sc_lev | input | LEV_W (7) | Level field of the request |
| sc_pc | input | XLEN (64) | PC of the system-call instruction |
| cur_msr | input | 64 | Machine state in force at the request |
| seq_pc | input | XLEN (64) | Next sequential fetch address |
| fetch_pc | output | XLEN (64) | Address fetch uses this cycle (redirect has priority) |
| trap_valid | output | 1 | One-cycle pulse: trap taken, state committed, flush fetch |
| redirect_pc | output | XLEN (64) | System-call vector address |
| new_msr | output | 64 | Machine state formed on trap entry |
| srr0 | output | XLEN (64) | Saved return address |
| srr1 | output | 64 | Saved old machine state |
| excp_valid | output | 1 | One-cycle pulse: illegal-instruction exception |
| excp_cause | output | 4 | Exception cause: 1 reserved level, 2 hypervisor call rejected |
| excp_pc | output | XLEN (64) | PC of the faulting system call |

## Verification
Every result is one register stage away from its request. A request driven after a falling edge and sampled on the next rising edge has its pulse, saved state and new machine state checked at the falling edge that follows. At that same point the bench drops `sc_valid`. An extra idle cycle, checked at its own falling edge, confirms that the pulse has ended and that `fetch_pc` has gone back to `seq_pc`. The bench builds one instance that accepts hypervisor calls and one that rejects them. It sweeps all 128 level values against several machine-state patterns. For each accepted trap it compares `new_msr` bit by bit with a mask it works out itself.

// File: rtl/sctrap_pkg.sv
package sctrap_pkg;

  localparam int MSR_W = 64;

  // machine-state bit positions (bit 0 = least significant)
  localparam int B_SF   = 63;
  localparam int B_HV   = 60;
  localparam int B_RSV5 = 58;
  localparam int B_TM   = 32;
  localparam int B_VEC  = 25;
  localparam int B_VSX  = 23;
  localparam int B_EE   = 15;
  localparam int B_PR   = 14;
  localparam int B_FP   = 13;
  localparam int B_TE1  = 10;
  localparam int B_TE0  = 9;
  localparam int B_IR   = 5;
  localparam int B_DR   = 4;
  localparam int B_PMM  = 2;
  localparam int B_RI   = 1;
  localparam int B_LE   = 0;

  localparam logic [3:0] CAUSE_NONE      = 4'h0;
  localparam logic [3:0] CAUSE_RSVD_LEV  = 4'h1;
  localparam logic [3:0] CAUSE_HV_REJECT = 4'h2;

  // bits forced to zero on trap entry
  function automatic logic [MSR_W-1:0] entry_clear_mask();
    logic [MSR_W-1:0] m;
    m = '0;
    m[B_EE]   = 1'b1;
    m[B_PR]   = 1'b1;
    m[B_IR]   = 1'b1;
    m[B_DR]   = 1'b1;
    m[B_RI]   = 1'b1;
    m[B_TM]   = 1'b1;
    m[B_VEC]  = 1'b1;
    m[B_VSX]  = 1'b1;
    m[B_FP]   = 1'b1;
    m[B_PMM]  = 1'b1;
    m[B_RSV5] = 1'b1;
    m[B_TE1]  = 1'b1;
    m[B_TE0]  = 1'b1;
    return m;
  endfunction

  // bits forced to one on trap entry
  function automatic logic [MSR_W-1:0] entry_set_mask();
    logic [MSR_W-1:0] m;
    m = '0;
    m[B_SF] = 1'b1;
    m[B_LE] = 1'b1;
    return m;
  endfunction

  function automatic logic [MSR_W-1:0] entry_msr(input logic [MSR_W-1:0] old,
                                                 input logic            hv_enter);
    logic [MSR_W-1:0] n;
    n = (old & ~entry_clear_mask()) | entry_set_mask();
    if (hv_enter) n[B_HV] = 1'b1;
    return n;
  endfunction

endpackage

// File: rtl/sctrap_lev_decode.sv
module sctrap_lev_decode #(
  parameter int LEV_W     = 7,
  parameter bit HV_ACCEPT = 1'b1
) (
  input  logic [LEV_W-1:0] lev,
  output logic             take_trap,
  output logic             hv_enter,
  output logic             illegal,
  output logic [3:0]       cause
);
  import sctrap_pkg::*;

  logic lev_rsvd;
  logic lev_hv;

  assign lev_rsvd = (lev > LEV_W'(1));
  assign lev_hv   = (lev == LEV_W'(1));

  generate
    if (HV_ACCEPT) begin : g_hv_trap
      assign take_trap = !lev_rsvd;
      assign hv_enter  = lev_hv;
      assign illegal   = lev_rsvd;
      assign cause     = lev_rsvd ? CAUSE_RSVD_LEV : CAUSE_NONE;
    end else begin : g_hv_fault
      assign take_trap = !lev_rsvd && !lev_hv;
      assign hv_enter  = 1'b0;
      assign illegal   = lev_rsvd || lev_hv;
      assign cause     = lev_rsvd ? CAUSE_RSVD_LEV :
                         (lev_hv ? CAUSE_HV_REJECT : CAUSE_NONE);
    end
  endgenerate

endmodule

// File: rtl/sctrap_msr_form.sv
module sctrap_msr_form (
  input  logic [63:0] old_msr,
  input  logic        hv_enter,
  output logic [63:0] next_msr
);
  import sctrap_pkg::*;

  always_comb begin
    next_msr = entry_msr(old_msr, hv_enter);
  end

endmodule

// File: rtl/sctrap_commit.sv
module sctrap_commit #(
  parameter int          XLEN     = 64,
  parameter logic [XLEN-1:0] VEC_ADDR = XLEN'(64'hC00)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            do_trap,
  input  logic            do_fault,
  input  logic [3:0]      fault_cause,
  input  logic [XLEN-1:0] req_pc,
  input  logic [63:0]     req_msr,
  input  logic [63:0]     formed_msr,
  output logic            trap_q,
  output logic [XLEN-1:0] redir_q,
  output logic [63:0]     msr_q,
  output logic [XLEN-1:0] srr0_q,
  output logic [63:0]     srr1_q,
  output logic            fault_q,
  output logic [3:0]      cause_q,
  output logic [XLEN-1:0] fault_pc_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_q     <= 1'b0;
      redir_q    <= '0;
      msr_q      <= '0;
      srr0_q     <= '0;
      srr1_q     <= '0;
      fault_q    <= 1'b0;
      cause_q    <= '0;
      fault_pc_q <= '0;
    end else begin
      trap_q  <= do_trap;
      fault_q <= do_fault;
      if (do_trap) begin
        redir_q <= VEC_ADDR;
        msr_q   <= formed_msr;
        srr0_q  <= req_pc + XLEN'(4);
        srr1_q  <= req_msr;
      end
      if (do_fault) begin
        cause_q    <= fault_cause;
        fault_pc_q <= req_pc;
      end
    end
  end

endmodule

// File: rtl/sctrap_unit.sv
module sctrap_unit #(
  parameter int              XLEN       = 64,
  parameter int              LEV_W      = 7,
  parameter logic [XLEN-1:0] VEC_BASE   = '0,
  parameter logic [XLEN-1:0] VEC_OFFSET = XLEN'(64'hC00),
  parameter bit              HV_ACCEPT  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sc_valid,
  input  logic [LEV_W-1:0] sc_lev,
  input  logic [XLEN-1:0]  sc_pc,
  input  logic [63:0]      cur_msr,
  input  logic [XLEN-1:0]  seq_pc,
  output logic [XLEN-1:0]  fetch_pc,
  output logic             trap_valid,
  output logic [XLEN-1:0]  redirect_pc,
  output logic [63:0]      new_msr,
  output logic [XLEN-1:0]  srr0,
  output logic [63:0]      srr1,
  output logic             excp_valid,
  output logic [3:0]       excp_cause,
  output logic [XLEN-1:0]  excp_pc
);

  localparam logic [XLEN-1:0] VEC_ADDR = VEC_BASE + VEC_OFFSET;

  // named internal events, observed by the checker
  logic       lev_take_w;
  logic       lev_hv_w;
  logic       lev_illegal_w;
  logic [3:0] lev_cause_w;
  logic       do_trap_w;
  logic       do_fault_w;
  logic [63:0] formed_msr_w;

  sctrap_lev_decode #(.LEV_W(LEV_W), .HV_ACCEPT(HV_ACCEPT)) dec_i (
    .lev       (sc_lev),
    .take_trap (lev_take_w),
    .hv_enter  (lev_hv_w),
    .illegal   (lev_illegal_w),
    .cause     (lev_cause_w)
  );

  sctrap_msr_form form_i (
    .old_msr  (cur_msr),
    .hv_enter (lev_hv_w),
    .next_msr (formed_msr_w)
  );

  assign do_trap_w  = sc_valid && lev_take_w;
  assign do_fault_w = sc_valid && lev_illegal_w;

  sctrap_commit #(.XLEN(XLEN), .VEC_ADDR(VEC_ADDR)) commit_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .do_trap     (do_trap_w),
    .do_fault    (do_fault_w),
    .fault_cause (lev_cause_w),
    .req_pc      (sc_pc),
    .req_msr     (cur_msr),
    .formed_msr  (formed_msr_w),
    .trap_q      (trap_valid),
    .redir_q     (redirect_pc),
    .msr_q       (new_msr),
    .srr0_q      (srr0),
    .srr1_q      (srr1),
    .fault_q     (excp_valid),
    .cause_q     (excp_cause),
    .fault_pc_q  (excp_pc)
  );

  // redirect wins over sequential fetch
  assign fetch_pc = trap_valid ? redirect_pc : seq_pc;

endmodule

// File: rtl/sctrap_unit_chk.sv
module sctrap_unit_chk #(
  parameter int              XLEN       = 64,
  parameter int              LEV_W      = 7,
  parameter logic [XLEN-1:0] VEC_BASE   = '0,
  parameter logic [XLEN-1:0] VEC_OFFSET = XLEN'(64'hC00)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sc_valid,
  input logic [LEV_W-1:0] sc_lev,
  input logic [XLEN-1:0]  sc_pc,
  input logic [63:0]      cur_msr,
  input logic [XLEN-1:0]  seq_pc,
  input logic [XLEN-1:0]  fetch_pc,
  input logic             trap_valid,
  input logic [XLEN-1:0]  redirect_pc,
  input logic [63:0]      new_msr,
  input logic [XLEN-1:0]  srr0,
  input logic [63:0]      srr1,
  input logic             excp_valid,
  input logic [3:0]       excp_cause,
  input logic             lev_hv_w,
  input logic             lev_take_w,
  input logic             lev_illegal_w
);
  import sctrap_pkg::*;

  a_r2_vector: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> redirect_pc == (VEC_BASE + VEC_OFFSET));

  a_r3_rsvd_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && sc_lev > LEV_W'(1)) |=> (excp_valid && !trap_valid && excp_cause == 4'h1));

  a_r4_hv_set: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && lev_hv_w) |=> (trap_valid && new_msr[B_HV]));

  a_r5_save: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (srr0 == $past(sc_pc) + XLEN'(4) && srr1 == $past(cur_msr)));

  a_r6_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (new_msr[B_SF] && new_msr[B_LE]));

  a_r7_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> !(new_msr[B_EE] || new_msr[B_PR] || new_msr[B_IR] || new_msr[B_DR] ||
                     new_msr[B_RI] || new_msr[B_TM] || new_msr[B_VEC] || new_msr[B_VSX] ||
                     new_msr[B_FP] || new_msr[B_PMM] || new_msr[B_RSV5] ||
                     new_msr[B_TE1] || new_msr[B_TE0]));

  a_r8_hv_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && lev_take_w && !lev_hv_w) |=> (new_msr[B_HV] == $past(cur_msr[B_HV])));

  a_r9_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
    excp_valid |-> ($stable(srr0) && $stable(srr1) && $stable(new_msr)));

  a_r10_fetch_seq: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |-> fetch_pc == seq_pc);

  a_r10_fetch_redir: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> fetch_pc == redirect_pc);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_valid, excp_valid}));

  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_valid |=> (!trap_valid && !excp_valid));

  a_r11_decode_excl: assert property (@(posedge clk) disable iff (!rst_n)
    sc_valid |-> $onehot({lev_take_w, lev_illegal_w}));

endmodule

bind sctrap_unit sctrap_unit_chk #(
  .XLEN(XLEN), .LEV_W(LEV_W), .VEC_BASE(VEC_BASE), .VEC_OFFSET(VEC_OFFSET)
) chk_i (
  .clk(clk), .rst_n(rst_n), .sc_valid(sc_valid), .sc_lev(sc_lev), .sc_pc(sc_pc),
  .cur_msr(cur_msr), .seq_pc(seq_pc), .fetch_pc(fetch_pc), .trap_valid(trap_valid),
  .redirect_pc(redirect_pc), .new_msr(new_msr), .srr0(srr0), .srr1(srr1),
  .excp_valid(excp_valid), .excp_cause(excp_cause), .lev_hv_w(lev_hv_w),
  .lev_take_w(lev_take_w), .lev_illegal_w(lev_illegal_w)
);

// File: tb/sctrap_unit_tb_top.sv
module sctrap_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sc_valid = 1'b0;
  logic [6:0]  sc_lev = '0;
  logic [63:0] sc_pc = '0;
  logic [63:0] cur_msr = '0;
  logic [63:0] seq_pc = 64'h1000;

  logic [63:0] a_fetch, a_redir, a_msr, a_srr0, a_srr1, a_epc;
  logic        a_trap, a_excp;
  logic [3:0]  a_cause;
  logic [63:0] b_fetch, b_redir, b_msr, b_srr0, b_srr1, b_epc;
  logic        b_trap, b_excp;
  logic [3:0]  b_cause;

  int n_vec = 0;
  int n_bad = 0;

  // held model state per instance
  logic [63:0] ha_srr0 = '0, ha_srr1 = '0, ha_msr = '0;
  logic [63:0] hb_srr0 = '0, hb_srr1 = '0, hb_msr = '0;

  always #2 clk = ~clk;

  sctrap_unit #(.HV_ACCEPT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .sc_valid(sc_valid), .sc_lev(sc_lev), .sc_pc(sc_pc),
    .cur_msr(cur_msr), .seq_pc(seq_pc), .fetch_pc(a_fetch), .trap_valid(a_trap),
    .redirect_pc(a_redir), .new_msr(a_msr), .srr0(a_srr0), .srr1(a_srr1),
    .excp_valid(a_excp), .excp_cause(a_cause), .excp_pc(a_epc)
  );

  sctrap_unit #(.HV_ACCEPT(1'b0)) dut_rej_i (
    .clk(clk), .rst_n(rst_n), .sc_valid(sc_valid), .sc_lev(sc_lev), .sc_pc(sc_pc),
    .cur_msr(cur_msr), .seq_pc(seq_pc), .fetch_pc(b_fetch), .trap_valid(b_trap),
    .redirect_pc(b_redir), .new_msr(b_msr), .srr0(b_srr0), .srr1(b_srr1),
    .excp_valid(b_excp), .excp_cause(b_cause), .excp_pc(b_epc)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected machine state, written per bit
  function automatic logic [63:0] ref_msr(input logic [63:0] old, input logic hv);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) begin
      case (i)
        63, 0:                                        r[i] = 1'b1;
        60:                                           r[i] = hv ? 1'b1 : old[i];
        15, 14, 5, 4, 1, 32, 25, 23, 13, 2, 58, 10, 9: r[i] = 1'b0;
        default:                                      r[i] = old[i];
      endcase
    end
    return r;
  endfunction

  task automatic check_trap(input string tag, input logic [6:0] lev, input logic [63:0] pc,
                            input logic [63:0] msr, input logic trap, input logic excp,
                            input logic [63:0] redir, input logic [63:0] fetch,
                            input logic [63:0] srr0, input logic [63:0] srr1,
                            input logic [63:0] nmsr);
    logic [63:0] e;
    e = ref_msr(msr, lev == 7'd1);
    check("R2", {tag, " trap_valid"}, 64'(trap), 64'd1);
    check("R11", {tag, " excp_valid low"}, 64'(excp), 64'd0);
    check("R2", {tag, " redirect_pc"}, redir, 64'hC00);
    check("R10", {tag, " fetch_pc redirect"}, fetch, 64'hC00);
    check("R5", {tag, " srr0"}, srr0, pc + 64'd4);
    check("R5", {tag, " srr1"}, srr1, msr);
    if (lev <= 7'd1) begin
      for (int i = 0; i < 64; i++) begin
        if (i == 63 || i == 0) check("R6", $sformatf("%s msr bit %0d", tag, i), 64'(nmsr[i]), 64'(e[i]));
        else if (i == 60) check(lev == 7'd1 ? "R4" : "R8", $sformatf("%s msr bit 60", tag), 64'(nmsr[i]), 64'(e[i]));
        else check(e[i] == msr[i] ? "R8" : "R7", $sformatf("%s msr bit %0d", tag, i), 64'(nmsr[i]), 64'(e[i]));
      end
    end
  endtask

  task automatic check_fault(input string tag, input logic [63:0] pc, input logic [3:0] ecause,
                             input logic trap, input logic excp, input logic [3:0] cause,
                             input logic [63:0] epc, input logic [63:0] srr0,
                             input logic [63:0] srr1, input logic [63:0] nmsr,
                             input logic [63:0] h0, input logic [63:0] h1, input logic [63:0] hm);
    check(ecause == 4'h1 ? "R3" : "R4", {tag, " excp_valid"}, 64'(excp), 64'd1);
    check(ecause == 4'h1 ? "R3" : "R4", {tag, " excp_cause"}, 64'(cause), 64'(ecause));
    check("R3", {tag, " excp_pc"}, epc, pc);
    check("R9", {tag, " no trap"}, 64'(trap), 64'd0);
    check("R9", {tag, " srr0 held"}, srr0, h0);
    check("R9", {tag, " srr1 held"}, srr1, h1);
    check("R9", {tag, " msr held"}, nmsr, hm);
  endtask

  task automatic apply(input logic [6:0] lev, input logic [63:0] pc, input logic [63:0] msr);
    @(negedge clk);
    sc_valid = 1'b1; sc_lev = lev; sc_pc = pc; cur_msr = msr;
    seq_pc = pc + 64'd4;
    @(negedge clk);
    sc_valid = 1'b0;
    // accepting instance
    if (lev <= 7'd1) begin
      check_trap("A", lev, pc, msr, a_trap, a_excp, a_redir, a_fetch, a_srr0, a_srr1, a_msr);
      ha_srr0 = pc + 64'd4; ha_srr1 = msr; ha_msr = ref_msr(msr, lev == 7'd1);
    end else begin
      check_fault("A", pc, 4'h1, a_trap, a_excp, a_cause, a_epc, a_srr0, a_srr1, a_msr,
                  ha_srr0, ha_srr1, ha_msr);
    end
    // rejecting instance
    if (lev == 7'd0) begin
      check_trap("B", lev, pc, msr, b_trap, b_excp, b_redir, b_fetch, b_srr0, b_srr1, b_msr);
      hb_srr0 = pc + 64'd4; hb_srr1 = msr; hb_msr = ref_msr(msr, 1'b0);
    end else begin
      check_fault("B", pc, lev == 7'd1 ? 4'h2 : 4'h1, b_trap, b_excp, b_cause, b_epc,
                  b_srr0, b_srr1, b_msr, hb_srr0, hb_srr1, hb_msr);
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    check("R11", "A pulse ended", 64'({a_trap, a_excp}), 64'd0);
    check("R11", "B pulse ended", 64'({b_trap, b_excp}), 64'd0);
    check("R10", "A fetch_pc sequential", a_fetch, seq_pc);
    check("R10", "B fetch_pc sequential", b_fetch, seq_pc);
  endtask

  function automatic logic [63:0] pattern(input int k, input int lev);
    logic [63:0] x;
    case (k % 4)
      0: x = 64'hFFFF_FFFF_FFFF_FFFF;
      1: x = 64'h0;
      2: x = 64'h5555_AAAA_5555_AAAA;
      default: begin
        x = 64'h9E37_79B9_7F4A_7C15 ^ 64'(lev * 7919);
        x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
      end
    endcase
    return x;
  endfunction

  initial begin : watchdog
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "A trap/excp", 64'({a_trap, a_excp}), 64'd0);
    check("R1", "B trap/excp", 64'({b_trap, b_excp}), 64'd0);
    check("R1", "A srr0", a_srr0, 64'd0);
    check("R1", "A srr1", a_srr1, 64'd0);
    check("R1", "A new_msr", a_msr, 64'd0);
    check("R1", "A excp_pc", a_epc, 64'd0);
    check("R1", "A excp_cause", 64'(a_cause), 64'd0);
    check("R1", "B new_msr", b_msr, 64'd0);

    // named corner levels: 0, 1, 2, 127 with each pattern
    for (int k = 0; k < 4; k++) begin
      apply(7'd0,   64'h2000 + 64'(k * 16), pattern(k, 0));
      apply(7'd1,   64'h3000 + 64'(k * 16), pattern(k, 1));
      apply(7'd2,   64'h4000 + 64'(k * 16), pattern(k, 2));
      idle_check();
      apply(7'd127, 64'h5000 + 64'(k * 16), pattern(k, 127));
    end

    // full sweep of level values against the patterns
    for (int k = 0; k < 4; k++) begin
      for (int lv = 0; lv < 128; lv++) begin
        apply(7'(lv), 64'h8000_0000 + 64'(lv * 8 + k * 4096), pattern(k + lv, lv));
        if ((lv % 16) == 0) idle_check();
      end
    end
    idle_check();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule